// File: doc/BRIEF.md
# Indirect Command-Word Register Bridge

This block gives a host a single 64-bit command register. Through it the host reaches the narrow 8-bit registers inside a two-wire serial controller. The host stores a command word with the launch bit set. The bridge then decodes the operation code, the direction bit and the sub-address, and strobes the selected internal register. When the access is finished, the bridge clears the launch bit. For a read, it also replaces the low data bits with the register contents. The host polls the word until the launch bit reads back as zero.

The serial engine itself is not part of the block. It is stood in for by a small register file. That file drives its contents out to the engine, takes a status byte from it, and raises one-hot read and write strobes so the engine sees each access. The fields the bridge does not decode pass through the command register unchanged. These fields are the bus address, the size, the scratch and the flag bits.

Top module: `ibr_bridge`

## Requirements
- R1: After reset the command word reads 0, all internal registers are 0, no strobe is active, and the status register holds the idle code 0xF8.
- R2: A host write whose bit 63 is 1, made while bit 63 of the stored word is 0, stores the whole word, and bit 63 reads back as 1 from the next cycle.
- R3: Bit 63 reads 1 for exactly two cycles after the launch edge and clears on the second edge after it. A register write takes effect on that same edge.
- R4: With operation code 6 in bits 60:57 and bit 56 = 0, the low byte of bits 31:0 is written to the register selected by bits 34:32: 0 own slave address, 1 data, 2 control, 3 clock divider, 4 extended slave address.
- R5: With operation code 6 and bit 56 = 1, completion sets bits 31:8 to 0 and bits 7:0 to the selected register. Sub-address 3 returns the status register, not the clock divider. Bits 62:32 keep the values the host wrote.
- R6: While bit 63 reads 1, host writes are ignored, and the access already in progress completes unchanged.
- R7: A launched word whose operation code is not 6 completes after the same latency. No register changes, and bits 62:0 read back as written.
- R8: A write to sub-address 7 clears the data, control and clock divider registers and sets the status register to 0xF8. The two slave address registers are left as they were.
- R9: A pulse on the status-valid input loads the status byte into the status register.
- R10: During the access cycle (the second cycle after launch), exactly the write strobe or the read strobe whose bit index equals the sub-address is high. No strobe is high in any other cycle or for an operation code other than 6.
- R11: A host write with bit 63 = 0, made while idle, stores the word without launching an access, and no register changes.
- R12: Sub-addresses 5 and 6 hold no register. A read of either returns 0 in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word from the host |
| host_rdata | output | 64 | Current command word, including the launch bit and read-back data |
| eng_stat_vld | input | 1 | Status byte from the engine is valid |
| eng_stat | input | 8 | Status byte from the engine |
| acc_wstb | output | 8 | One-hot write strobe per sub-address |
| acc_rstb | output | 8 | One-hot read strobe per sub-address |
| reg_saddr | output | 8 | Own slave address register |
| reg_xsaddr | output | 8 | Extended slave address register |
| reg_data | output | 8 | Data register |
| reg_ctl | output | 8 | Control register |
| reg_clkdiv | output | 8 | Clock divider register |
| reg_status | output | 8 | Status register |

## Verification
Each writable sub-address is written with a distinct byte and then read back. This tells a wrong sub-address decode apart from a wrong data path. Reading sub-address 3 after writing the clock divider shows whether the read and write meanings of that address are kept apart. A word with a foreign operation code, a word stored without its launch bit, and a second write made during a busy access show that the launch gating and the opcode gating are separate. A soft reset issued after non-zero values were loaded shows which registers it touches and which it leaves alone.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    parameter int CMD_W    = 64;
    parameter int DATA_W   = 32;
    parameter int REG_W    = 8;
    parameter int SUB_W    = 3;
    parameter int OP_W     = 4;
    localparam int NUM_SUB = 1 << SUB_W;

    // Field positions that the decoder relies on
    localparam int VLD_BIT = 63;
    localparam int DIR_BIT = 56;
    localparam int OP_LSB  = 57;
    localparam int SUB_LSB = 32;

    localparam logic [OP_W-1:0]  OP_REG    = 4'd6;
    localparam logic [REG_W-1:0] STAT_IDLE = 8'hF8;

    localparam int SUB_SADDR  = 0;
    localparam int SUB_DATA   = 1;
    localparam int SUB_CTL    = 2;
    localparam int SUB_CLK    = 3;
    localparam int SUB_XSADDR = 4;
    localparam int SUB_SRST   = 7;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_DECODE = 2'd1,
        PH_ACCESS = 2'd2
    } phase_e;

    typedef struct packed {
        logic             is_reg;
        logic             rd;
        logic [SUB_W-1:0] sub;
        logic [REG_W-1:0] wbyte;
    } acc_t;

endpackage

// File: rtl/ibr_cmd_decode.sv
module ibr_cmd_decode
    import ibr_pkg::*;
(
    input  logic             dir_bit,
    input  logic [OP_W-1:0]  op,
    input  logic [SUB_W-1:0] sub,
    input  logic [REG_W-1:0] wbyte,
    output acc_t             acc
);

    always_comb begin
        acc        = '0;
        acc.is_reg = (op == OP_REG);
        acc.rd     = dir_bit;
        acc.sub    = sub;
        acc.wbyte  = wbyte;
    end

endmodule

// File: rtl/ibr_strobe_gen.sv
module ibr_strobe_gen
    import ibr_pkg::*;
(
    input  logic               access_en,
    input  acc_t               acc,
    output logic [NUM_SUB-1:0] wstb,
    output logic [NUM_SUB-1:0] rstb
);

    for (genvar i = 0; i < NUM_SUB; i++) begin : g_stb
        logic hit;
        assign hit     = access_en && acc.is_reg && (acc.sub == SUB_W'(i));
        assign wstb[i] = hit && !acc.rd;
        assign rstb[i] = hit &&  acc.rd;
    end

endmodule

// File: rtl/ibr_regfile.sv
module ibr_regfile
    import ibr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SUB-1:0] wstb,
    input  logic [REG_W-1:0]   wbyte,
    input  logic [SUB_W-1:0]   rd_sub,
    input  logic               stat_vld,
    input  logic [REG_W-1:0]   stat_in,
    output logic [REG_W-1:0]   rd_byte,
    output logic [REG_W-1:0]   saddr,
    output logic [REG_W-1:0]   xsaddr,
    output logic [REG_W-1:0]   data,
    output logic [REG_W-1:0]   ctl,
    output logic [REG_W-1:0]   clkdiv,
    output logic [REG_W-1:0]   status
);

    typedef struct packed {
        logic [REG_W-1:0] saddr;
        logic [REG_W-1:0] xsaddr;
        logic [REG_W-1:0] data;
        logic [REG_W-1:0] ctl;
        logic [REG_W-1:0] clkdiv;
        logic [REG_W-1:0] status;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (stat_vld)            rf_d.status = stat_in;
        if (wstb[SUB_SADDR])     rf_d.saddr  = wbyte;
        if (wstb[SUB_XSADDR])    rf_d.xsaddr = wbyte;
        if (wstb[SUB_DATA])      rf_d.data   = wbyte;
        if (wstb[SUB_CTL])       rf_d.ctl    = wbyte;
        if (wstb[SUB_CLK])       rf_d.clkdiv = wbyte;
        if (wstb[SUB_SRST]) begin
            rf_d.data   = '0;
            rf_d.ctl    = '0;
            rf_d.clkdiv = '0;
            rf_d.status = STAT_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q        <= '0;
            rf_q.status <= STAT_IDLE;
        end else begin
            rf_q <= rf_d;
        end
    end

    // Read side: sub-address 3 shows status, not the clock divider
    always_comb begin
        case (rd_sub)
            SUB_W'(SUB_SADDR):  rd_byte = rf_q.saddr;
            SUB_W'(SUB_DATA):   rd_byte = rf_q.data;
            SUB_W'(SUB_CTL):    rd_byte = rf_q.ctl;
            SUB_W'(SUB_CLK):    rd_byte = rf_q.status;
            SUB_W'(SUB_XSADDR): rd_byte = rf_q.xsaddr;
            default:            rd_byte = '0;
        endcase
    end

    assign saddr  = rf_q.saddr;
    assign xsaddr = rf_q.xsaddr;
    assign data   = rf_q.data;
    assign ctl    = rf_q.ctl;
    assign clkdiv = rf_q.clkdiv;
    assign status = rf_q.status;

endmodule

// File: rtl/ibr_cmd_ctrl.sv
module ibr_cmd_ctrl
    import ibr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic [CMD_W-1:0] host_wdata,
    input  acc_t             acc_dec,
    input  logic [REG_W-1:0] rd_byte,
    output logic [CMD_W-1:0] cmd,
    output acc_t             acc,
    output logic             access_en
);

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        phase_e           phase;
        acc_t             acc;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        case (c_q.phase)
            PH_IDLE: begin
                if (host_wr) begin
                    c_d.cmd = host_wdata;
                    if (host_wdata[VLD_BIT]) c_d.phase = PH_DECODE;
                end
            end
            PH_DECODE: begin
                c_d.acc   = acc_dec;
                c_d.phase = PH_ACCESS;
            end
            PH_ACCESS: begin
                c_d.cmd[VLD_BIT] = 1'b0;
                if (c_q.acc.is_reg && c_q.acc.rd)
                    c_d.cmd[DATA_W-1:0] = {{(DATA_W-REG_W){1'b0}}, rd_byte};
                c_d.phase = PH_IDLE;
            end
            default: c_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cmd       = c_q.cmd;
    assign acc       = c_q.acc;
    assign access_en = (c_q.phase == PH_ACCESS);

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [CMD_W-1:0]   host_wdata,
    output logic [CMD_W-1:0]   host_rdata,
    input  logic               eng_stat_vld,
    input  logic [REG_W-1:0]   eng_stat,
    output logic [NUM_SUB-1:0] acc_wstb,
    output logic [NUM_SUB-1:0] acc_rstb,
    output logic [REG_W-1:0]   reg_saddr,
    output logic [REG_W-1:0]   reg_xsaddr,
    output logic [REG_W-1:0]   reg_data,
    output logic [REG_W-1:0]   reg_ctl,
    output logic [REG_W-1:0]   reg_clkdiv,
    output logic [REG_W-1:0]   reg_status
);

    logic [CMD_W-1:0] cmd;
    acc_t             acc_dec, acc_q;
    logic             access_en;
    logic [REG_W-1:0] rd_byte;

    ibr_cmd_decode u_dec (
        .dir_bit (cmd[DIR_BIT]),
        .op      (cmd[OP_LSB +: OP_W]),
        .sub     (cmd[SUB_LSB +: SUB_W]),
        .wbyte   (cmd[REG_W-1:0]),
        .acc     (acc_dec)
    );

    ibr_cmd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .acc_dec    (acc_dec),
        .rd_byte    (rd_byte),
        .cmd        (cmd),
        .acc        (acc_q),
        .access_en  (access_en)
    );

    ibr_strobe_gen u_stb (
        .access_en (access_en),
        .acc       (acc_q),
        .wstb      (acc_wstb),
        .rstb      (acc_rstb)
    );

    ibr_regfile u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wstb     (acc_wstb),
        .wbyte    (acc_q.wbyte),
        .rd_sub   (acc_q.sub),
        .stat_vld (eng_stat_vld),
        .stat_in  (eng_stat),
        .rd_byte  (rd_byte),
        .saddr    (reg_saddr),
        .xsaddr   (reg_xsaddr),
        .data     (reg_data),
        .ctl      (reg_ctl),
        .clkdiv   (reg_clkdiv),
        .status   (reg_status)
    );

    assign host_rdata = cmd;

endmodule

// File: rtl/ibr_bridge_chk.sv
module ibr_bridge_chk
    import ibr_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [CMD_W-1:0]   host_wdata,
    input logic [CMD_W-1:0]   host_rdata,
    input logic [NUM_SUB-1:0] acc_wstb,
    input logic [NUM_SUB-1:0] acc_rstb,
    input logic [REG_W-1:0]   reg_data,
    input logic [REG_W-1:0]   reg_ctl,
    input logic [REG_W-1:0]   reg_clkdiv,
    input logic [REG_W-1:0]   reg_status
);

    a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[VLD_BIT] && !host_rdata[VLD_BIT]) |=> host_rdata[VLD_BIT]);

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rdata[VLD_BIT]) |=> host_rdata[VLD_BIT] ##1 !host_rdata[VLD_BIT]);

    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[VLD_BIT] |=> (host_rdata[62:32] == $past(host_rdata[62:32])));

    a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wstb[SUB_SRST] |=> (reg_data == '0 && reg_ctl == '0 &&
                                reg_clkdiv == '0 && reg_status == STAT_IDLE));

    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_wstb, acc_rstb}));

    a_r10_busy_only: assert property (@(posedge clk) disable iff (!rst_n)
        (|{acc_wstb, acc_rstb}) |-> host_rdata[VLD_BIT]);

    a_r10_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        (|{acc_wstb, acc_rstb}) |=> !host_rdata[VLD_BIT]);

    a_r11_store: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_wdata[VLD_BIT] && !host_rdata[VLD_BIT]) |=>
        (host_rdata == $past(host_wdata)));

endmodule

bind ibr_bridge ibr_bridge_chk chk_i (.*);

// File: tb/ibr_bridge_tb_top.sv
module ibr_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [63:0] host_wdata = '0;
    logic [63:0] host_rdata;
    logic        eng_stat_vld = 1'b0;
    logic [7:0]  eng_stat = '0;
    logic [7:0]  acc_wstb, acc_rstb;
    logic [7:0]  reg_saddr, reg_xsaddr, reg_data, reg_ctl, reg_clkdiv, reg_status;

    always #10 clk = ~clk;

    ibr_bridge dut_i (.*);

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    // Reference copies of the registers
    logic [7:0] m_saddr = 0, m_xsaddr = 0, m_data = 0, m_ctl = 0, m_clk = 0, m_stat = 8'hF8;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic go, input logic [3:0] op, input logic dir,
                                       input logic [2:0] sub, input logic [31:0] d);
        return {go, 1'b1, 1'b0, op, dir, 1'b0, 3'd5, 2'b01, 10'h2A5, 5'h0B, sub, d};
    endfunction

    // Monitor: pops one expectation at each completion
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && !host_rdata[63]) begin
                if (exp_q.size() == 0) chk(1'b0, "R3 unexpected completion", host_rdata, 64'h0);
                else begin
                    automatic logic [63:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(host_rdata == e, t, host_rdata, e);
                end
            end
            prev_v = host_rdata[63];
        end
    end

    // Launch one word, check latency and strobes; expectation goes to the scoreboard
    task automatic run_cmd(input logic [63:0] w, input logic [63:0] e, input string tag);
        logic [7:0] ew, er;
        ew = (w[60:57] == 4'd6 && !w[56]) ? (8'd1 << w[34:32]) : 8'd0;
        er = (w[60:57] == 4'd6 &&  w[56]) ? (8'd1 << w[34:32]) : 8'd0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); host_wr = 1'b1; host_wdata = w;
        @(negedge clk); host_wr = 1'b0;
        chk(host_rdata[63] == 1'b1, "R2 launch bit set", {63'd0, host_rdata[63]}, 64'd1);
        chk({acc_wstb, acc_rstb} == 16'd0, "R10 no strobe in decode cycle", {48'd0, acc_wstb, acc_rstb}, 64'd0);
        @(negedge clk);
        chk(host_rdata[63] == 1'b1, "R3 still busy second cycle", {63'd0, host_rdata[63]}, 64'd1);
        chk(acc_wstb == ew && acc_rstb == er, "R10 strobe in access cycle",
            {48'd0, acc_wstb, acc_rstb}, {48'd0, ew, er});
        @(negedge clk);
        chk(host_rdata[63] == 1'b0, "R3 cleared after two cycles", {63'd0, host_rdata[63]}, 64'd0);
    endtask

    task automatic wr_reg(input logic [2:0] sub, input logic [7:0] b, input string tag);
        logic [63:0] w;
        w = mk(1'b1, 4'd6, 1'b0, sub, {24'hABCDEF, b});
        run_cmd(w, {1'b0, w[62:0]}, tag);
        case (sub)
            3'd0: m_saddr = b;
            3'd1: m_data = b;
            3'd2: m_ctl = b;
            3'd3: m_clk = b;
            3'd4: m_xsaddr = b;
            3'd7: begin m_data = 0; m_ctl = 0; m_clk = 0; m_stat = 8'hF8; end
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [2:0] sub, input string tag);
        logic [63:0] w;
        logic [7:0]  v;
        case (sub)
            3'd0: v = m_saddr;
            3'd1: v = m_data;
            3'd2: v = m_ctl;
            3'd3: v = m_stat;
            3'd4: v = m_xsaddr;
            default: v = 8'h00;
        endcase
        w = mk(1'b1, 4'd6, 1'b1, sub, 32'h5A5A5A5A);
        run_cmd(w, {1'b0, w[62:32], 24'd0, v}, tag);
    endtask

    task automatic chk_regs(input string tag);
        chk({reg_saddr, reg_xsaddr, reg_data, reg_ctl, reg_clkdiv, reg_status} ==
            {m_saddr, m_xsaddr, m_data, m_ctl, m_clk, m_stat}, tag,
            {16'd0, reg_saddr, reg_xsaddr, reg_data, reg_ctl, reg_clkdiv, reg_status},
            {16'd0, m_saddr, m_xsaddr, m_data, m_ctl, m_clk, m_stat});
    endtask

    initial begin
        #4_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] w1, w2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(host_rdata == 64'd0, "R1 command word after reset", host_rdata, 64'd0);
        chk({acc_wstb, acc_rstb} == 16'd0, "R1 strobes idle", {48'd0, acc_wstb, acc_rstb}, 64'd0);
        chk_regs("R1 register reset values");

        // R4 writes to each writable register
        wr_reg(3'd0, 8'h55, "R4 write slave address");
        wr_reg(3'd1, 8'hA3, "R4 write data");
        wr_reg(3'd2, 8'h44, "R4 write control");
        wr_reg(3'd3, 8'h3B, "R4 write clock divider");
        wr_reg(3'd4, 8'h7E, "R4 write extended slave address");
        chk_regs("R4 register outputs after writes");

        // R5 read-back, sub-address 3 reads status
        rd_reg(3'd1, "R5 read data");
        rd_reg(3'd2, "R5 read control");
        rd_reg(3'd0, "R5 read slave address");
        rd_reg(3'd4, "R5 read extended slave address");
        rd_reg(3'd3, "R5 read status not clock divider");

        // R9 status input
        @(negedge clk); eng_stat_vld = 1'b1; eng_stat = 8'h18;
        @(negedge clk); eng_stat_vld = 1'b0; m_stat = 8'h18;
        chk(reg_status == 8'h18, "R9 status captured", {56'd0, reg_status}, 64'h18);
        rd_reg(3'd3, "R9 status read back");

        // R12 empty sub-addresses
        wr_reg(3'd5, 8'hCC, "R12 write to empty sub-address");
        rd_reg(3'd5, "R12 read sub-address 5");
        rd_reg(3'd6, "R12 read sub-address 6");
        chk_regs("R12 no register touched");

        // R7 foreign operation code
        w1 = mk(1'b1, 4'd1, 1'b0, 3'd1, 32'h000000FF);
        run_cmd(w1, {1'b0, w1[62:0]}, "R7 foreign opcode write completes");
        w1 = mk(1'b1, 4'd9, 1'b1, 3'd2, 32'h12345678);
        run_cmd(w1, {1'b0, w1[62:0]}, "R7 foreign opcode read keeps data");
        chk_regs("R7 registers unchanged");

        // R6 write during a busy access is dropped
        w1 = mk(1'b1, 4'd6, 1'b1, 3'd1, 32'h0);
        w2 = mk(1'b1, 4'd6, 1'b0, 3'd2, 32'h000000EE);
        exp_q.push_back({1'b0, w1[62:32], 24'd0, m_data});
        tag_q.push_back("R6 busy write ignored, first access intact");
        @(negedge clk); host_wr = 1'b1; host_wdata = w1;
        @(negedge clk); host_wdata = w2;
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk);
        chk(host_rdata[63] == 1'b0, "R6 no second launch", {63'd0, host_rdata[63]}, 64'd0);
        repeat (2) @(negedge clk);
        chk(reg_ctl == m_ctl, "R6 control untouched", {56'd0, reg_ctl}, {56'd0, m_ctl});

        // R11 store without launch
        w1 = mk(1'b0, 4'd6, 1'b0, 3'd2, 32'h00000099);
        @(negedge clk); host_wr = 1'b1; host_wdata = w1;
        @(negedge clk); host_wr = 1'b0;
        chk(host_rdata == w1, "R11 word stored", host_rdata, w1);
        repeat (3) @(negedge clk);
        chk(host_rdata == w1, "R11 word held, no launch", host_rdata, w1);
        chk_regs("R11 registers unchanged");

        // R8 soft reset
        wr_reg(3'd7, 8'h00, "R8 soft reset command");
        chk_regs("R8 soft reset effect, slave addresses kept");
        rd_reg(3'd3, "R8 status back to idle code");
        rd_reg(3'd0, "R8 slave address kept");

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R3 every launch completed", 64'(exp_q.size()), 64'd0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule